// File: doc/BRIEF.md
# I2C EEPROM Slave Controller

This block is a bit-level two-wire serial slave for a 128-byte nonvolatile memory model. A fast system clock oversamples the serial clock and serial data lines. The block finds START and STOP conditions and shifts in the select and address bytes. It drives a single open-drain enable: when that enable is high, the data line is pulled low, either to acknowledge or to send a zero read bit. It serves current-address, random and sequential reads, and it takes one-byte writes.

A completed write is not stored at once. At STOP it is handed to an internal program sequencer over a valid/ready channel. The protocol side raises valid and holds the address and data steady until ready is seen. The sequencer is ready only while it is idle, so back-pressure can stall a request but never drop it. While a program cycle runs, the block reports busy and does not acknowledge its select byte, so a bus master can poll for completion. A write-lock input, sampled from START until the address byte ends, blocks the data byte.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the data-line enable and busy are low, and every memory byte reads 8'hFF.
- R2: The first byte after START is, MSB first, 1010, then the three strap bits, then a direction bit (1 = read, 0 = write). The enable is asserted during the 9th clock only when the strap bits equal `chip_sel_i`. Otherwise the byte is not acknowledged and the block stays silent until the next START.
- R3: After a write-type select, the next byte is acknowledged and loads the address counter from its low 7 bits. Bit 7 of that byte is ignored.
- R4: An acknowledged data byte is committed only at STOP. Busy then rises, stays high for PROG_CYCLES system clocks, and the memory holds the new byte once busy falls.
- R5: The address counter increments after each acknowledged write byte and after each byte sent. A current-address read returns the byte at the counter.
- R6: A write-type select plus an address byte, followed by a repeated START and a read-type select, returns the byte at that address.
- R7: A sequential read continues for as long as the master acknowledges. The address wraps from 127 to 0.
- R8: When the master does not acknowledge a read byte, the block releases the line and does not drive it again until a START.
- R9: While busy is high, the select byte is not acknowledged and the enable stays low.
- R10: If `wr_lock_i` is high at any time from START through the end of the address byte, the select and address bytes are acknowledged, the data byte is not, and the memory is unchanged.
- R11: Only the first data byte of a write command is acknowledged and stored. Later data bytes are not acknowledged and are not stored.
- R12: A START arriving in the middle of a byte aborts the transfer, discards any uncommitted write, and restarts select-byte reception.
- R13: The enable rises only while the synchronized serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| sda_oe_o | output | 1 | High pulls the data line low |
| chip_sel_i | input | 3 | Strap value matched against the select byte |
| wr_lock_i | input | 1 | Write lock; high blocks data bytes |
| busy_o | output | 1 | High while a write awaits or undergoes programming |

## Verification
A wrong address counter shows up at the next read data byte, within one byte time of the fault. That covers a lost increment, a missed wrap, or a counter loaded with the wrong bits. A wrong protocol state shows up as a wrong acknowledge bit in the 9th clock of the same byte, or as the data line driven where it should be released. Program-cycle faults show up on busy within a few system clocks of STOP. They also show up as a wrong byte in the first read after busy falls.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_SEL,
    PS_ADDR,
    PS_WDATA,
    PS_RDATA
  } pstate_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_prog.sv
module eep_prog #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int PROG_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(PROG_CYCLES + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data;
  logic          busy_r;

  assign req_ready = ~busy_r;
  assign busy      = busy_r;
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      cnt      <= '0;
      lat_addr <= '0;
      lat_data <= '0;
      busy_r   <= 1'b0;
    end else if (req_valid && !busy_r) begin
      lat_addr <= req_addr;
      lat_data <= req_data;
      cnt      <= CW'(PROG_CYCLES);
      busy_r   <= 1'b1;
    end else if (busy_r) begin
      if (cnt == CW'(1)) begin
        mem[lat_addr] <= lat_data;
        busy_r        <= 1'b0;
      end
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/eep_proto.sv
module eep_proto
  import eep_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [2:0]    chip_sel,
  input  logic          wr_lock,
  input  logic          busy_in,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          sda_oe,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  pstate_t       st, nxt;
  logic [3:0]    bitcnt;
  logic [DW-1:0] shreg;
  logic [AW-1:0] ctr;
  logic          lock_lat, pend, mack;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;

  assign rd_addr = ctr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_IDLE;
      nxt       <= PS_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ctr       <= '0;
      lock_lat  <= 1'b0;
      pend      <= 1'b0;
      mack      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      sda_oe    <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;

      if (start_det) begin
        st       <= PS_SEL;
        bitcnt   <= '0;
        sda_oe   <= 1'b0;
        pend     <= 1'b0;
        lock_lat <= wr_lock;
      end else if (stop_det) begin
        st     <= PS_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        if (pend) begin
          wr_valid <= 1'b1;
          wr_addr  <= pend_addr;
          wr_data  <= pend_data;
          pend     <= 1'b0;
        end
      end else begin
        if (st == PS_SEL || st == PS_ADDR) lock_lat <= lock_lat | wr_lock;

        case (st)
          PS_SEL, PS_ADDR, PS_WDATA: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= 4'd9;
              if (st == PS_SEL) begin
                if (shreg[7:1] == {DEV_TYPE, chip_sel} && !busy_in) begin
                  sda_oe <= 1'b1;
                  nxt    <= shreg[0] ? PS_RDATA : PS_ADDR;
                end else begin
                  st     <= PS_IDLE;
                  bitcnt <= '0;
                end
              end else if (st == PS_ADDR) begin
                ctr    <= shreg[AW-1:0];
                sda_oe <= 1'b1;
                nxt    <= PS_WDATA;
              end else begin
                nxt <= PS_WDATA;
                if (!lock_lat && !pend) begin
                  pend      <= 1'b1;
                  pend_addr <= ctr;
                  pend_data <= shreg;
                  ctr       <= ctr + 1'b1;
                  sda_oe    <= 1'b1;
                end
              end
            end else if (scl_fall && bitcnt == 4'd9) begin
              bitcnt <= '0;
              st     <= nxt;
              if (nxt == PS_RDATA) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[DW-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end

          PS_RDATA: begin
            if (scl_rise && bitcnt <= 4'd8) begin
              if (bitcnt == 4'd8) mack <= ~sda_s;
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                sda_oe <= ~shreg[DW-2];
                shreg  <= shreg << 1;
              end else if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ctr    <= ctr + 1'b1;
              end else if (bitcnt == 4'd9) begin
                bitcnt <= '0;
                if (mack) begin
                  shreg  <= rd_data;
                  sda_oe <= ~rd_data[DW-1];
                end else begin
                  st     <= PS_IDLE;
                  sda_oe <= 1'b0;
                end
              end
            end
          end

          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] chip_sel_i,
  input  logic       wr_lock_i,
  output logic       busy_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_valid, wr_ready, prog_busy;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  assign busy_o = prog_busy | wr_valid;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_proto #(.AW(ADDR_W), .DW(DATA_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .chip_sel(chip_sel_i), .wr_lock(wr_lock_i), .busy_in(busy_o),
    .rd_data(rd_data), .rd_addr(rd_addr), .sda_oe(sda_oe_o),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  eep_prog #(.AW(ADDR_W), .DW(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n), .req_valid(wr_valid), .req_ready(wr_ready),
    .req_addr(wr_addr), .req_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(prog_busy)
  );
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          busy,
  input logic          stop_det,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_data
);
  p_drive_on_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  p_quiet_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data));

  p_req_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(stop_det));

  p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy);
endmodule

bind i2c_eeprom_slave eep_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s), .busy(busy_o),
  .stop_det(stop_det), .req_valid(wr_valid), .req_ready(wr_ready),
  .req_addr(wr_addr), .req_data(wr_data)
);

// File: tb/sim_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_slave;
  localparam int Q = 8;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, CS, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, CS, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, mlow = 1'b0, lock = 1'b0;
  logic oe, busy;
  wire  sda_line = ~(mlow | oe);
  int   n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q [$];

  always #2 clk = ~clk;

  i2c_eeprom_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(oe),
    .chip_sel_i(CS), .wr_lock_i(lock), .busy_o(busy)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    mlow = 1'b0; tick(Q); scl = 1'b1; tick(2*Q); mlow = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    mlow = 1'b1; tick(Q); scl = 1'b1; tick(2*Q); mlow = 1'b0; tick(2*Q);
  endtask

  task automatic wbit(input logic b);
    mlow = ~b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic rbit(output logic b, output bit stable);
    logic b0, b1;
    mlow = 1'b0; tick(Q); scl = 1'b1; b0 = sda_line; tick(Q); b = sda_line; tick(Q);
    b1 = sda_line; scl = 1'b0; tick(Q);
    stable = (b0 == b) && (b1 == b);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b; bit s;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b, s);
    ack = ~b;
  endtask

  // monitor side of the scoreboard: receive a byte and compare with the queue head
  task automatic get_byte(input bit master_ack, input string tag);
    logic [7:0] v; logic b; bit s, all_stable;
    logic [7:0] e;
    all_stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      rbit(b, s);
      v[i] = b;
      all_stable &= s;
    end
    wbit(~master_ack);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    chk(v === e, tag, v, e);
    chk(all_stable, "R13 read bit stable while clock high", all_stable, 1);
  endtask

  task automatic wait_prog(input string tag);
    int n;
    chk(busy === 1'b1, {tag, " R4 busy after STOP"}, busy, 1);
    n = 0;
    while (busy && n < 5000) begin tick(1); n++; end
    chk(busy === 1'b0, {tag, " R4 busy clears"}, busy, 0);
  endtask

  task automatic write_cmd(input logic [7:0] abyte, input logic [7:0] d, input string tag);
    bit a;
    bus_start();
    send_byte(SEL_W, a); chk(a, {tag, " R2 select ack"}, a, 1);
    send_byte(abyte, a); chk(a, {tag, " R3 address ack"}, a, 1);
    send_byte(d, a);     chk(a, {tag, " R4 data ack"}, a, 1);
    bus_stop();
    wait_prog(tag);
  endtask

  task automatic rand_read(input logic [7:0] addr, input int n, input string tag);
    bit a;
    bus_start();
    send_byte(SEL_W, a); chk(a, {tag, " R6 dummy select ack"}, a, 1);
    send_byte(addr, a);  chk(a, {tag, " R6 address ack"}, a, 1);
    bus_start();
    send_byte(SEL_R, a); chk(a, {tag, " R6 read select ack"}, a, 1);
    for (int i = 0; i < n; i++) get_byte(i < n - 1, tag);
    bus_stop();
  endtask

  task automatic cur_read(input string tag);
    bit a;
    bus_start();
    send_byte(SEL_R, a); chk(a, {tag, " R2 read select ack"}, a, 1);
    get_byte(1'b0, tag);
    bus_stop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit a;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk(oe === 1'b0, "R1 enable low after reset", oe, 0);
    chk(busy === 1'b0, "R1 busy low after reset", busy, 0);
    exp_q.push_back(8'hFF);
    cur_read("R1 erased byte at 0");

    write_cmd(8'h80, 8'h42, "R3 top address bit ignored");

    // write with ACK polling while busy
    bus_start();
    send_byte(SEL_W, a); send_byte(8'h05, a); send_byte(8'hA5, a);
    chk(a, "R4 data ack at 05", a, 1);
    bus_stop();
    tick(2);
    chk(busy === 1'b1, "R4 busy during program", busy, 1);
    bus_start();
    send_byte(SEL_W, a);
    chk(!a, "R9 select not acked while busy", a, 0);
    bus_stop();
    wait_prog("R9 poll");

    write_cmd(8'h06, 8'h5A, "R4 write 06");
    exp_q.push_back(8'hFF);
    cur_read("R5 counter after write is 07");

    exp_q.push_back(8'hA5); exp_q.push_back(8'h5A);
    rand_read(8'h05, 2, "R7 sequential from 05");

    // master nack then idle clocks: line must stay released
    bus_start();
    send_byte(SEL_R, a); chk(a, "R5 current read select ack", a, 1);
    exp_q.push_back(8'hFF);
    get_byte(1'b0, "R5 current read at 07");
    for (int i = 0; i < 9; i++) begin
      logic b; bit s;
      rbit(b, s);
      chk(b === 1'b1, "R8 released after master nack", b, 1);
    end
    bus_stop();

    write_cmd(8'h7F, 8'hC3, "R4 write 7F");
    exp_q.push_back(8'hC3); exp_q.push_back(8'h42);
    rand_read(8'h7F, 2, "R7 wrap 127 to 0");

    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, a);
    chk(!a, "R2 mismatched strap not acked", a, 0);
    bus_stop();

    // write lock raised during the address byte
    bus_start();
    send_byte(SEL_W, a); chk(a, "R10 select acked under lock", a, 1);
    lock = 1'b1;
    send_byte(8'h10, a); chk(a, "R10 address acked under lock", a, 1);
    lock = 1'b0;
    send_byte(8'h99, a); chk(!a, "R10 data not acked", a, 0);
    bus_stop();
    tick(4);
    chk(busy === 1'b0, "R10 no program cycle", busy, 0);
    exp_q.push_back(8'hFF);
    rand_read(8'h10, 1, "R10 memory unchanged");

    // extra data byte
    bus_start();
    send_byte(SEL_W, a); send_byte(8'h20, a);
    send_byte(8'h11, a); chk(a, "R11 first data acked", a, 1);
    send_byte(8'h22, a); chk(!a, "R11 second data not acked", a, 0);
    bus_stop();
    wait_prog("R11");
    exp_q.push_back(8'h11); exp_q.push_back(8'hFF);
    rand_read(8'h20, 2, "R11 only first byte stored");

    // START inside a byte after an accepted data byte
    bus_start();
    send_byte(SEL_W, a); send_byte(8'h30, a);
    send_byte(8'h77, a); chk(a, "R12 data acked before abort", a, 1);
    wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b0);
    bus_start();
    send_byte(SEL_R, a); chk(a, "R12 select after mid-byte START", a, 1);
    exp_q.push_back(8'hFF);
    get_byte(1'b0, "R12 read at counter 31");
    bus_stop();
    tick(4);
    chk(busy === 1'b0, "R12 aborted write not committed", busy, 0);
    exp_q.push_back(8'hFF);
    rand_read(8'h30, 1, "R12 memory at 30 unchanged");

    summary();
  end
endmodule